// File: doc/BRIEF.md
# Latchable Parity Bus Transceiver

This block joins two 9-bit ports, A and B, each carrying eight data bits and one parity bit. A word enters on one port, passes through a transparent latch belonging to that port, and is driven out of the other port. On the way out, the parity bit is either copied from the incoming word (feed-through) or replaced by a freshly computed bit (generate). Each port's latch has its own enable. With the enable HIGH the latch follows its input; with it LOW the latch keeps the last word it took.

Parity is checked on both sides at the same time. The source side always checks the word held in its latch. The destination side checks the word that the block is driving out, which passes through the destination latch as an echo. Each side reports its result on an active-LOW fault output. Tri-state pins are split into an input, an output and an output-enable for each port.

Top module: `parity_latch_xcvr`

## Requirements
- R1: Port A is driven (`a_oe` HIGH) exactly when `drv_a_n` is LOW and `drv_b_n` is HIGH. Port B is driven exactly when `drv_b_n` is LOW and `drv_a_n` is HIGH. With both controls HIGH, neither port is driven.
- R2: With both `drv_a_n` and `drv_b_n` LOW, neither port is driven and both fault outputs are held HIGH.
- R3: The data bits driven on the destination port equal the data bits held in the source port's latch.
- R4: With `feed_thru` LOW, the driven parity bit is the XOR of the 8 source data bits, inverted when `par_odd` is HIGH. The 9-bit driven word therefore has an even count of ones when `par_odd` is LOW and an odd count when it is HIGH.
- R5: With `feed_thru` HIGH, the driven parity bit equals the parity bit held in the source port's latch.
- R6: A port's latch follows that port's input pins while its open input (`open_a` or `open_b`) is HIGH. While the open input is LOW, the latch holds its last word, and the source data and parity bits it supplies are unaffected by changes on those pins.
- R7: The fault output of an undriven port is LOW exactly when the 9-bit word in that port's latch breaks the selected parity. This holds in both generate and feed-through mode. With `par_odd` LOW, the word breaks parity when its count of ones is odd; with `par_odd` HIGH, when the count is even.
- R8: The fault output of the driven port checks the driven word as echoed through that port's latch. While the port's latch is open, the fault output is HIGH in generate mode and repeats the source-side verdict in feed-through mode.
- R9: When the driven port's latch is closed, its fault output keeps checking the last driven word the latch took, even if the driven word changes.
- R10: The input pins of a port that is being driven are ignored. After the port becomes a source again with its latch closed, it forwards the word it held before it was driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| drv_a_n | input | 1 | Active-LOW enable for driving port A |
| drv_b_n | input | 1 | Active-LOW enable for driving port B |
| feed_thru | input | 1 | HIGH copies the source parity bit; LOW generates a new one |
| par_odd | input | 1 | Parity sense: LOW even, HIGH odd |
| open_a | input | 1 | HIGH makes the port-A latch transparent |
| open_b | input | 1 | HIGH makes the port-B latch transparent |
| a_dat_i | input | 8 | Port A data pins, inbound |
| a_par_i | input | 1 | Port A parity pin, inbound |
| a_dat_o | output | 8 | Port A data, outbound (zero when not driven) |
| a_par_o | output | 1 | Port A parity, outbound (zero when not driven) |
| a_oe | output | 1 | Port A output enable |
| b_dat_i | input | 8 | Port B data pins, inbound |
| b_par_i | input | 1 | Port B parity pin, inbound |
| b_dat_o | output | 8 | Port B data, outbound (zero when not driven) |
| b_par_o | output | 1 | Port B parity, outbound (zero when not driven) |
| b_oe | output | 1 | Port B output enable |
| fault_a_n | output | 1 | Port A parity check, LOW on mismatch |
| fault_b_n | output | 1 | Port B parity check, LOW on mismatch |

## Verification
The sweep crosses all 64 settings of the six control inputs with sixteen data and parity patterns, so every open/closed and direction combination is reached from varied latch histories. A design that lets a closed latch leak would forward the live pins instead of the held word. A design that inverts the parity sense would fail every generate-mode word and every fault output. Directed sequences then target three cases. First, the echo check with its latch closed (R9), where a design that checks the live driven word would clear a fault it should keep. Second, pins changing while their port is driven (R10), where a design that lets them into its latch would later forward garbage. Third, the undefined case with both enables active (R2), where a design that does not special-case it would drive a port or report a fault.

// File: rtl/parity_latch_xcvr.sv
module parity_latch_xcvr #(
  parameter int DW = 8
) (
  input  logic          drv_a_n,
  input  logic          drv_b_n,
  input  logic          feed_thru,
  input  logic          par_odd,
  input  logic          open_a,
  input  logic          open_b,
  input  logic [DW-1:0] a_dat_i,
  input  logic          a_par_i,
  output logic [DW-1:0] a_dat_o,
  output logic          a_par_o,
  output logic          a_oe,
  input  logic [DW-1:0] b_dat_i,
  input  logic          b_par_i,
  output logic [DW-1:0] b_dat_o,
  output logic          b_par_o,
  output logic          b_oe,
  output logic          fault_a_n,
  output logic          fault_b_n
);

  localparam int WW = DW + 1;

  function automatic logic gen_par(input logic [DW-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  logic          clash;
  logic [WW-1:0] a_rx, b_rx;
  logic [WW-1:0] a_echo, b_echo;
  logic [WW-1:0] a_word, b_word;
  logic [WW-1:0] a_view, b_view;

  assign clash = !drv_a_n && !drv_b_n;
  assign a_oe  = !drv_a_n && drv_b_n;
  assign b_oe  = !drv_b_n && drv_a_n;

  // inbound latches: take pins only while the port is a receiver
  always_latch begin
    if (open_a && !a_oe) a_rx <= {a_dat_i, a_par_i};
  end

  always_latch begin
    if (open_b && !b_oe) b_rx <= {b_dat_i, b_par_i};
  end

  // outbound words
  assign b_word = {a_rx[WW-1:1], feed_thru ? a_rx[0] : gen_par(a_rx[WW-1:1], par_odd)};
  assign a_word = {b_rx[WW-1:1], feed_thru ? b_rx[0] : gen_par(b_rx[WW-1:1], par_odd)};

  // echo latches: take the driven word back for the destination check
  always_latch begin
    if (open_a && a_oe) a_echo <= a_word;
  end

  always_latch begin
    if (open_b && b_oe) b_echo <= b_word;
  end

  assign a_view = a_oe ? a_echo : a_rx;
  assign b_view = b_oe ? b_echo : b_rx;

  assign fault_a_n = clash | ~((^a_view) ^ par_odd);
  assign fault_b_n = clash | ~((^b_view) ^ par_odd);

  assign a_dat_o = a_oe ? a_word[WW-1:1] : '0;
  assign a_par_o = a_oe ? a_word[0] : 1'b0;
  assign b_dat_o = b_oe ? b_word[WW-1:1] : '0;
  assign b_par_o = b_oe ? b_word[0] : 1'b0;

  always_comb begin
    // R1
    oe_excl_chk: assert (!(a_oe && b_oe));
    if (clash) begin
      // R2
      clash_quiet_chk: assert (fault_a_n && fault_b_n && !a_oe && !b_oe);
    end
    if (b_oe && !feed_thru) begin
      // R4
      b_gen_word_chk: assert ((^{b_dat_o, b_par_o}) == par_odd);
    end
    if (a_oe && !feed_thru) begin
      // R4
      a_gen_word_chk: assert ((^{a_dat_o, a_par_o}) == par_odd);
    end
    if (b_oe && feed_thru && open_a) begin
      // R5
      b_feed_copy_chk: assert (b_par_o == a_par_i && b_dat_o == a_dat_i);
    end
    if (a_oe && feed_thru && open_b) begin
      // R5
      a_feed_copy_chk: assert (a_par_o == b_par_i && a_dat_o == b_dat_i);
    end
    if (b_oe && !feed_thru && open_b) begin
      // R8
      b_echo_ok_chk: assert (fault_b_n);
    end
    if (a_oe && !feed_thru && open_a) begin
      // R8
      a_echo_ok_chk: assert (fault_a_n);
    end
  end

endmodule

// File: tb/test_parity_latch_xcvr.sv
`timescale 1ns/1ps
module test_parity_latch_xcvr;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       drv_a_n = 1'b1, drv_b_n = 1'b1, feed_thru = 1'b0, par_odd = 1'b0;
  logic       open_a = 1'b0, open_b = 1'b0;
  logic [7:0] a_dat_i = '0, b_dat_i = '0;
  logic       a_par_i = 1'b0, b_par_i = 1'b0;
  logic [7:0] a_dat_o, b_dat_o;
  logic       a_par_o, b_par_o, a_oe, b_oe, fault_a_n, fault_b_n;

  parity_latch_xcvr #(.DW(8)) i_parity_latch_xcvr (
    .drv_a_n(drv_a_n), .drv_b_n(drv_b_n), .feed_thru(feed_thru), .par_odd(par_odd),
    .open_a(open_a), .open_b(open_b),
    .a_dat_i(a_dat_i), .a_par_i(a_par_i), .a_dat_o(a_dat_o), .a_par_o(a_par_o), .a_oe(a_oe),
    .b_dat_i(b_dat_i), .b_par_i(b_par_i), .b_dat_o(b_dat_o), .b_par_o(b_par_o), .b_oe(b_oe),
    .fault_a_n(fault_a_n), .fault_b_n(fault_b_n)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [8:0] m_arx = 'x, m_brx = 'x, m_aecho = 'x, m_becho = 'x;

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    if ($isunknown(exp)) return;
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic da, input logic db, input logic ft, input logic od,
                      input logic oa, input logic ob,
                      input logic [7:0] ad, input logic ap, input logic [7:0] bd, input logic bp);
    logic eao, ebo, clash, efa, efb;
    logic [8:0] aw, bw, av, bv;
    @(posedge clk);
    drv_a_n = da; drv_b_n = db; feed_thru = ft; par_odd = od;
    open_a = oa; open_b = ob;
    a_dat_i = ad; a_par_i = ap; b_dat_i = bd; b_par_i = bp;
    eao = !da && db;
    ebo = !db && da;
    clash = !da && !db;
    if (oa && !eao) m_arx = {ad, ap};
    if (ob && !ebo) m_brx = {bd, bp};
    bw = {m_arx[8:1], ft ? m_arx[0] : ((^m_arx[8:1]) ^ od)};
    aw = {m_brx[8:1], ft ? m_brx[0] : ((^m_brx[8:1]) ^ od)};
    if (oa && eao) m_aecho = aw;
    if (ob && ebo) m_becho = bw;
    av = eao ? m_aecho : m_arx;
    bv = ebo ? m_becho : m_brx;
    efa = clash ? 1'b1 : ~((^av) ^ od);
    efb = clash ? 1'b1 : ~((^bv) ^ od);
    @(negedge clk);
    chk("R1 a_oe", 9'(a_oe), 9'(eao));
    chk("R1 b_oe", 9'(b_oe), 9'(ebo));
    if (eao) begin
      chk("R3 a_dat_o", 9'(a_dat_o), 9'(aw[8:1]));
      if (ft) chk("R5 a_par_o", 9'(a_par_o), 9'(aw[0]));
      else    chk("R4 a_par_o", 9'(a_par_o), 9'(aw[0]));
    end
    if (ebo) begin
      chk("R3 b_dat_o", 9'(b_dat_o), 9'(bw[8:1]));
      if (ft) chk("R5 b_par_o", 9'(b_par_o), 9'(bw[0]));
      else    chk("R4 b_par_o", 9'(b_par_o), 9'(bw[0]));
    end
    if (clash) begin
      chk("R2 fault_a_n", 9'(fault_a_n), 9'(1'b1));
      chk("R2 fault_b_n", 9'(fault_b_n), 9'(1'b1));
    end else begin
      chk(eao ? "R8 fault_a_n" : "R7 fault_a_n", 9'(fault_a_n), 9'(efa));
      chk(ebo ? "R8 fault_b_n" : "R7 fault_b_n", 9'(fault_b_n), 9'(efb));
    end
  endtask

  logic done = 1'b0;

  initial begin
    // power-up: open both latches with neither port driven, then load echoes
    step(1, 1, 0, 0, 1, 1, 8'h3C, 1'b0, 8'hA5, 1'b1);
    chk("R7 idle A", 9'(fault_a_n), 9'(1'b1));
    chk("R7 idle B", 9'(fault_b_n), 9'(1'b0));
    chk("R1 idle", {7'd0, a_oe, b_oe}, 9'd0);
    step(0, 1, 0, 0, 1, 1, 8'h00, 1'b0, 8'h11, 1'b0);
    step(1, 0, 0, 0, 1, 1, 8'h22, 1'b0, 8'h00, 1'b0);

    for (int p = 0; p < 16; p++) begin
      for (int c = 0; c < 64; c++) begin
        step(c[0], c[1], c[2], c[3], c[4], c[5],
             8'(p * 29 + c * 7), p[0] ^ c[1] ^ c[4],
             8'(p * 53 + c * 13 + 1), p[1] ^ c[0] ^ c[3]);
      end
    end

    // R6: closed source latch holds the word
    step(1, 0, 1, 0, 1, 1, 8'h5A, 1'b0, 8'h00, 1'b0);
    chk("R6 open", 9'(b_dat_o), 9'h5A);
    step(1, 0, 1, 0, 0, 1, 8'hFF, 1'b1, 8'h00, 1'b0);
    chk("R6 hold", 9'(b_dat_o), 9'h5A);
    chk("R6 hold par", 9'(b_par_o), 9'(1'b0));

    // R10: pins of a driven port do not reach its latch
    step(0, 1, 1, 0, 1, 1, 8'h33, 1'b1, 8'h0F, 1'b0);
    chk("R10 driven A", 9'(a_dat_o), 9'h0F);
    step(1, 0, 1, 0, 0, 1, 8'hC3, 1'b1, 8'h00, 1'b0);
    chk("R10 held word", 9'(b_dat_o), 9'h5A);

    // R9: echo latch closed keeps checking the old driven word
    step(0, 1, 1, 0, 1, 1, 8'h00, 1'b0, 8'h0F, 1'b1);
    chk("R9 src bad", 9'(fault_b_n), 9'(1'b0));
    chk("R9 echo bad", 9'(fault_a_n), 9'(1'b0));
    step(0, 1, 1, 0, 0, 1, 8'h00, 1'b0, 8'h0F, 1'b0);
    chk("R9 src good", 9'(fault_b_n), 9'(1'b1));
    chk("R9 echo held", 9'(fault_a_n), 9'(1'b0));

    // R2: both enables active
    step(0, 0, 0, 1, 1, 1, 8'h01, 1'b0, 8'h03, 1'b0);
    chk("R2 quiet", {5'd0, a_oe, b_oe, fault_a_n, fault_b_n}, 9'b000000011);

    // R4: odd sense explicit
    step(1, 0, 0, 1, 1, 1, 8'h07, 1'b0, 8'h00, 1'b0);
    chk("R4 odd gen", 9'(b_par_o), 9'(1'b0));
    step(1, 0, 0, 0, 1, 1, 8'h07, 1'b0, 8'h00, 1'b0);
    chk("R4 even gen", 9'(b_par_o), 9'(1'b1));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule